// File: doc/BRIEF.md
# Booth-Recoded Compressor-Tree Signed Multiplier

This block multiplies two 16-bit two's-complement operands and returns the full 32-bit signed product. The multiplier operand is recoded into eight radix-4 digits in the range -2..+2. Digit j selects 0, ±A or ±2A, weighted by 4^j. Negative multiples are formed by inverting the selected multiple and injecting a one at that row's lowest position.

Each row keeps only 16 data bits plus one inverted sign bit, so no row is sign-extended. A single constant row (upper half 1010101010101011, lower half zero) cancels the ones that the inverted sign bits imply. That constant is merged into the upper bits of the first row. The rows then pass through two levels of 4-2 compressors, each built per column from two chained full adders. Two 4-2 compressors reduce eight rows to four, a third reduces four to two, and a carry-propagate adder forms the result.

A parameter selects whether the product leaves through a register (the default, one cycle of latency, asynchronous active-low clear) or directly from the adder. There is no handshake. The operands present at each rising edge define the product seen after that edge.

Top module: `bwm_mult16`

## Requirements
- R1: With the output register on, `prod` after a rising edge equals the 32-bit two's-complement product of `op_a` and `op_b` sampled at that edge.
- R2: While `rst_n` is low, `prod` is zero, and the clear takes effect without waiting for a clock edge.
- R3: An operand change between two rising edges leaves `prod` unchanged until the next rising edge.
- R4: When either operand is zero, the next `prod` is zero.
- R5: The extreme operands give exact results: -32768 × -32768 = 0x40000000 and -32768 × 32767 = 0xC0008000.
- R6: While both operands stay constant, `prod` stays constant.
- R7: A multiplier whose every radix-4 digit is negative gives the exact product. Digit j is -2·b[2j+1] + b[2j] + b[2j-1], with b[-1] = 0. The value 0xAAAA yields digits -2, -1, -1, -1, -1, -1, -1, -1.
- R8: A multiplier whose top digit is -2 (bits 15..13 equal 100) gives the exact product, including the case where the top row must hold +65536 (multiplicand -32768).
- R9: Swapping the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the product register |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement, Booth-recoded |
| prod | output | 32 | Signed product |

## Verification
The hardest case arises when two corrections act on the same column in one product. The first is the injected one that completes the negation of the top row. The second is the constant row that undoes the inverted sign bits. Both meet the carry chain through column 14 upward, and this happens when the top digit is -2 and the multiplicand is -32768. The bench provokes it with the multiplicand fixed at -32768 and several multipliers whose upper three bits are 100, and with the all-negative-digit multiplier against a sweep of multiplicands. Every result is compared with the signed product computed in the bench.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    localparam int OPW   = 16;        // operand width
    localparam int PW    = 2 * OPW;   // product width
    localparam int NROWS = OPW / 2;   // radix-4 digits / partial-product rows
    localparam int MW    = OPW + 1;   // width of a selected multiple (up to 2A)

    // Constant row that cancels the ones implied by the inverted sign bits:
    // minus the sum of 2^(OPW + 2j) over all rows, modulo 2^PW.
    function automatic logic [PW-1:0] sign_fix_row();
        logic [PW-1:0] acc;
        acc = '0;
        for (int j = 0; j < NROWS; j++) begin
            acc = acc + (PW'(1) << (OPW + 2 * j));
        end
        return (~acc) + PW'(1);
    endfunction

    // Place a row at weight 4^idx: data bits, inverted sign bit above them,
    // and the previous row's negation one two columns below.
    function automatic logic [PW-1:0] place_row(
        input logic [MW-1:0] v,
        input logic          neg_lo,
        input int            idx
    );
        logic [PW-1:0] r;
        r = '0;
        for (int k = 0; k < OPW; k++) begin
            r[2 * idx + k] = v[k];
        end
        r[2 * idx + OPW] = ~v[OPW];
        r[2 * idx - 2]   = neg_lo;
        return r;
    endfunction

endpackage

// File: rtl/bwm_booth_sel.sv
module bwm_booth_sel
    import bwm_pkg::*;
(
    input  logic [OPW-1:0] op_a,
    input  logic [2:0]     trip,
    output logic [MW-1:0]  mult,
    output logic           neg
);

    logic [MW-1:0] mag;

    // Digit = -2*trip[2] + trip[1] + trip[0]; a negative digit inverts the
    // multiple, the +1 is injected into the next row.
    always_comb begin
        mag = '0;
        neg = 1'b0;
        unique case (trip)
            3'b000, 3'b111: begin
                mag = '0;
                neg = 1'b0;
            end
            3'b001, 3'b010: begin
                mag = {op_a[OPW-1], op_a};
                neg = 1'b0;
            end
            3'b011: begin
                mag = {op_a, 1'b0};
                neg = 1'b0;
            end
            3'b100: begin
                mag = {op_a, 1'b0};
                neg = 1'b1;
            end
            3'b101, 3'b110: begin
                mag = {op_a[OPW-1], op_a};
                neg = 1'b1;
            end
            default: begin
                mag = '0;
                neg = 1'b0;
            end
        endcase
        mult = neg ? ~mag : mag;
    end

endmodule

// File: rtl/bwm_comp42.sv
module bwm_comp42
    import bwm_pkg::*;
#(
    parameter int N = PW
) (
    input  logic [N-1:0] in0,
    input  logic [N-1:0] in1,
    input  logic [N-1:0] in2,
    input  logic [N-1:0] in3,
    output logic [N-1:0] sum,
    output logic [N-1:0] carry
);

    logic [N-1:0] chain;   // lateral carry into each column
    logic [N-1:0] s_first;

    assign chain[0] = 1'b0;
    assign carry[0] = 1'b0;

    for (genvar c = 0; c < N; c++) begin : g_col
        // first full adder: three row bits
        assign s_first[c] = in0[c] ^ in1[c] ^ in2[c];
        // second full adder: first sum, fourth row bit, lateral carry in
        assign sum[c] = s_first[c] ^ in3[c] ^ chain[c];
        if (c < N - 1) begin : g_up
            assign chain[c+1] = (in0[c] & in1[c]) | (in0[c] & in2[c]) | (in1[c] & in2[c]);
            assign carry[c+1] = (s_first[c] & in3[c]) | (s_first[c] & chain[c])
                              | (in3[c] & chain[c]);
        end
    end

endmodule

// File: rtl/bwm_final_add.sv
module bwm_final_add
    import bwm_pkg::*;
#(
    parameter int INJ_POS = 14
) (
    input  logic [PW-1:0] srow,
    input  logic [PW-1:0] crow,
    input  logic          inj,
    output logic [PW-1:0] total
);

    assign total = srow + crow + (PW'(inj) << INJ_POS);

endmodule

// File: rtl/bwm_mult16.sv
module bwm_mult16
    import bwm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic [PW-1:0]  prod
);

    localparam logic [PW-1:0] FIX     = sign_fix_row();
    localparam int            INJ_POS = 2 * (NROWS - 1);

    logic [OPW:0]       b_ext;
    logic [MW-1:0]      mult [NROWS];
    logic [NROWS-1:0]   neg;
    logic [PW-1:0]      pp   [NROWS];
    logic [PW-1:0]      s1a, c1a, s1b, c1b, s2, c2, sum_w;

    assign b_ext = {op_b, 1'b0};

    for (genvar j = 0; j < NROWS; j++) begin : g_row
        bwm_booth_sel u_sel (
            .op_a (op_a),
            .trip (b_ext[2*j +: 3]),
            .mult (mult[j]),
            .neg  (neg[j])
        );
        if (j == 0) begin : g_first
            // inverted sign plus the constant row folded: bits 18..16 = ~s, s, s
            assign pp[j] = {FIX[PW-1:OPW+3], ~mult[j][OPW], mult[j][OPW],
                            mult[j][OPW], mult[j][OPW-1:0]};
        end else begin : g_rest
            assign pp[j] = place_row(mult[j], neg[j-1], j);
        end
    end

    bwm_comp42 #(.N(PW)) u_l1a (
        .in0 (pp[0]), .in1 (pp[1]), .in2 (pp[2]), .in3 (pp[3]),
        .sum (s1a),   .carry (c1a)
    );

    bwm_comp42 #(.N(PW)) u_l1b (
        .in0 (pp[4]), .in1 (pp[5]), .in2 (pp[6]), .in3 (pp[7]),
        .sum (s1b),   .carry (c1b)
    );

    bwm_comp42 #(.N(PW)) u_l2 (
        .in0 (s1a), .in1 (c1a), .in2 (s1b), .in3 (c1b),
        .sum (s2),  .carry (c2)
    );

    bwm_final_add #(.INJ_POS(INJ_POS)) u_cpa (
        .srow  (s2),
        .crow  (c2),
        .inj   (neg[NROWS-1]),
        .total (sum_w)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod <= '0;
            end else begin
                prod <= sum_w;
            end
        end
    end else begin : g_comb
        assign prod = sum_w;
    end

endmodule

// File: rtl/bwm_mult16_chk.sv
module bwm_mult16_chk
    import bwm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_a,
    input logic [OPW-1:0] op_b,
    input logic [PW-1:0]  prod
);

    logic [PW-1:0] ref_v;
    assign ref_v = PW'($signed(op_a)) * PW'($signed(op_b));

    if (OUT_REG) begin : g_seq
        // R1: registered product equals the signed product of the sampled operands
        a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> prod == $past(ref_v));

        // R2: clear holds the product at zero
        a_r2_reset: assert property (@(posedge clk)
            !rst_n |=> prod == '0);

        // R4: a zero operand gives a zero product
        a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a == '0 || op_b == '0) |=> prod == '0);

        // R6: steady operands keep the product steady
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(prod));
    end else begin : g_cmb
        // R1: unregistered variant
        a_r1_product_comb: assert property (@(posedge clk) prod == ref_v);
    end

endmodule

bind bwm_mult16 bwm_mult16_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_bwm_mult16.sv
`timescale 1ns/1ps
module sim_bwm_mult16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic [31:0] prod;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bwm_mult16 u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod)
    );

    function automatic logic [31:0] mulref(input logic [15:0] x, input logic [15:0] y);
        return 32'($signed(x)) * 32'($signed(y));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply_check(input string tag, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
        check(tag, prod, mulref(a, b));
    endtask

    // R2: clear at start and mid-run
    task automatic t_reset();
        op_a = 16'h1234;
        op_b = 16'h0F0F;
        @(negedge clk);
        check("R2 start", prod, 32'h0);
        @(negedge clk);
        check("R2 start held", prod, 32'h0);
        rst_n = 1'b1;
        apply_check("R1 after release", 16'h1234, 16'h0F0F);
        #2 rst_n = 1'b0;
        #1 check("R2 async clear", prod, 32'h0);
        @(negedge clk);
        check("R2 clear held", prod, 32'h0);
        rst_n = 1'b1;
        apply_check("R1 after second release", 16'hFFFF, 16'h7FFF);
    endtask

    // R5, R4 and R1 over every pair of corner operands
    task automatic t_corners();
        logic [15:0] cv [12] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'hFFFE,
                                 16'h7FFF, 16'h8000, 16'h8001, 16'h5555, 16'hAAAA,
                                 16'h4000, 16'hC000};
        for (int i = 0; i < 12; i++) begin
            for (int k = 0; k < 12; k++) begin
                apply_check("R1 corner", cv[i], cv[k]);
            end
        end
        apply_check("R5 min*min", 16'h8000, 16'h8000);
        check("R5 min*min const", prod, 32'h4000_0000);
        apply_check("R5 min*max", 16'h8000, 16'h7FFF);
        check("R5 min*max const", prod, 32'hC000_8000);
    endtask

    task automatic t_zero();
        apply_check("R4 a zero", 16'h0000, 16'h8000);
        check("R4 a zero const", prod, 32'h0);
        apply_check("R4 b zero", 16'hBEEF, 16'h0000);
        check("R4 b zero const", prod, 32'h0);
    endtask

    // R3: change between edges must not reach prod before the next edge
    task automatic t_latency();
        apply_check("R3 setup", 16'h0123, 16'h0456);
        @(negedge clk);
        op_a = 16'h8000;
        op_b = 16'h8000;
        #2 check("R3 before edge", prod, mulref(16'h0123, 16'h0456));
        @(negedge clk);
        check("R3 after edge", prod, 32'h4000_0000);
    endtask

    // R6: constant operands keep prod constant
    task automatic t_hold();
        apply_check("R6 load", 16'h9ABC, 16'h3210);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R6 hold", prod, mulref(16'h9ABC, 16'h3210));
        end
    endtask

    // R7: every digit negative
    task automatic t_all_neg();
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a = 16'($urandom);
            apply_check("R7 all-negative digits", a, 16'hAAAA);
        end
        apply_check("R7 min", 16'h8000, 16'hAAAA);
        apply_check("R7 max", 16'h7FFF, 16'hAAAA);
    endtask

    // R8: top digit -2, with and without the largest multiple
    task automatic t_top_neg2();
        logic [15:0] bv [6] = '{16'h8000, 16'h8001, 16'h8FFF, 16'h9234, 16'h9FFF, 16'h8AAA};
        for (int i = 0; i < 6; i++) begin
            apply_check("R8 top -2 min a", 16'h8000, bv[i]);
            apply_check("R8 top -2 any a", 16'($urandom), bv[i]);
        end
    endtask

    // R9: operand swap
    task automatic t_commute();
        for (int i = 0; i < 50; i++) begin
            logic [15:0] x = 16'($urandom);
            logic [15:0] y = 16'($urandom);
            logic [31:0] first;
            apply_check("R9 order xy", x, y);
            first = prod;
            apply_check("R9 order yx", y, x);
            check("R9 swap equal", prod, first);
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 20000; i++) begin
            apply_check("R1 random", 16'($urandom), 16'($urandom));
        end
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles == 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_a  = 16'h0;
        op_b  = 16'h0;
        t_reset();
        t_zero();
        t_corners();
        t_latency();
        t_hold();
        t_all_neg();
        t_top_neg2();
        t_commute();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule